// File: doc/BRIEF.md
# Call, Trap and Return Control Unit

This block steers the program counter of a small 16-bit processor for four control-flow operations: a system trap, a PC-relative subroutine call, a register-indirect subroutine call and a return. A decode stage presents one operation at a time together with the already incremented program counter. The unit sees the whole general register file as a flat input bus. It produces the registered next program counter and a write of the return address into the link register (register 7).

A system trap is an indirect call through a table of routine addresses that fills the lowest 256 words of memory. The unit zero-extends the 8-bit trap number into a table address and makes a one-cycle read request on a synchronous memory port. It then waits for the read-valid strobe and commits the fetched word as the new program counter. The two call forms and the return each finish in a single cycle. Every committed operation raises a one-cycle completion strobe. While a trap fetch is in flight, the unit reports itself busy and accepts nothing new.

Top module: `flow_call_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, pc_out reads 0x3000 and mem_req, done, link_we and busy are all low.
- R2: An accepted operation with code 0 (trap) drives mem_req high for exactly the one cycle after the accepting edge. In that cycle mem_addr equals bits [7:0] of instr_field, zero-extended to 16 bits, and busy is high.
- R3: During a trap, the first mem_valid that comes after the request cycle commits the trap. In the next cycle pc_out equals the mem_rdata sampled with that strobe, link_we and done are high, link_data equals the pc_inc captured when the trap was accepted, and busy is low.
- R4: Operation code 1 (relative call) sets pc_out to pc_inc plus instr_field sign-extended from bit 10. It also writes pc_inc to the link register. Both are visible in the cycle after acceptance.
- R5: Operation code 2 (register call) sets pc_out to the register chosen by instr_rsel, where register i occupies rf_flat[16*i+15:16*i]. It writes pc_inc to the link register. The register is read before the link write, so a call through register 7 jumps to its old value.
- R6: Operation code 3 (return) sets pc_out to register 7 in the cycle after acceptance. It does not raise link_we.
- R7: done is high for exactly one cycle for each committed operation, and link_we is never high without done. An operation presented in a done cycle is accepted and commits in turn.
- R8: An operation presented while busy is high is ignored. It changes neither pc_out nor the link register, raises no done and starts no request.
- R9: mem_valid is ignored when no trap is waiting, in the idle state and in the request cycle alike. It leaves pc_out unchanged and raises no done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An operation is presented this cycle |
| instr_op | input | 2 | Operation code: 0 trap, 1 relative call, 2 register call, 3 return |
| instr_field | input | 11 | Call offset (signed), or trap number in bits [7:0] |
| instr_rsel | input | 3 | Register index for the register call |
| pc_inc | input | 16 | Incremented program counter of the presented operation |
| rf_flat | input | 128 | Contents of the eight general registers, register i in bits [16*i+15:16*i] |
| mem_req | output | 1 | Vector-table read request, one cycle |
| mem_addr | output | 16 | Vector-table read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pc_out | output | 16 | Registered program counter |
| link_we | output | 1 | Link register write enable |
| link_data | output | 16 | Value to write into the link register |
| done | output | 1 | Completion strobe, one cycle per committed operation |
| busy | output | 1 | A trap fetch is in progress |

## Verification
The bench builds the unit with its default parameters: a 16-bit datapath, eight registers with register 7 as the link, an 11-bit call offset and an 8-bit trap number. With these values the offset extremes +1023 and -1024 and the first and last table entries (0x00 and 0xFF) can be reached directly. The responder's latency runs from zero to several wait cycles, which reaches both the request-cycle strobe that must be ignored and long waits during which further operations are rejected. A call through register 7 and a return right after a trap test the read-before-write order of the link register.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

   typedef enum logic [1:0] {
      OP_TRAP = 2'd0,
      OP_JSR  = 2'd1,
      OP_JSRR = 2'd2,
      OP_RET  = 2'd3
   } fcu_op_e;

   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_REQ  = 2'd1,
      VS_WAIT = 2'd2
   } vs_state_e;

endpackage

// File: rtl/fcu_target.sv
// Single-cycle target selection for the relative call, the register call
// and the return. Pure combinational logic; the caller registers the result.
module fcu_target
   import fcu_pkg::*;
#(
   parameter int DW       = 16,
   parameter int NREG     = 8,
   parameter int OFS_W    = 11,
   parameter int LINK_IDX = 7,
   localparam int SEL_W   = $clog2(NREG)
) (
   input  logic [1:0]         op,
   input  logic [OFS_W-1:0]   field,
   input  logic [SEL_W-1:0]   sel,
   input  logic [DW-1:0]      pc_inc,
   input  logic [NREG*DW-1:0] rf_flat,
   output logic [DW-1:0]      target,
   output logic               link_en,
   output logic               is_fast
);

   logic [DW-1:0] regs [NREG];
   logic [DW-1:0] ofs_ext;

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign regs[g] = rf_flat[g*DW +: DW];
   end

   if (OFS_W < DW) begin : g_sext
      assign ofs_ext = {{(DW-OFS_W){field[OFS_W-1]}}, field};
   end else begin : g_full
      assign ofs_ext = field[DW-1:0];
   end

   always_comb begin
      target  = pc_inc;
      link_en = 1'b0;
      is_fast = 1'b1;
      unique case (fcu_op_e'(op))
         OP_JSR: begin
            target  = pc_inc + ofs_ext;
            link_en = 1'b1;
         end
         OP_JSRR: begin
            target  = regs[sel];
            link_en = 1'b1;
         end
         OP_RET: begin
            target  = regs[LINK_IDX];
         end
         default: begin
            is_fast = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fcu_vec_seq.sv
// Trap sequencer: idle, one request cycle, wait for valid data, commit.
module fcu_vec_seq
   import fcu_pkg::*;
#(
   parameter int DW    = 16,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] vec,
   input  logic [DW-1:0]    link_in,
   input  logic             mem_valid,
   input  logic [DW-1:0]    mem_rdata,
   output logic             mem_req,
   output logic [DW-1:0]    mem_addr,
   output logic             busy,
   output logic             commit,
   output logic [DW-1:0]    commit_pc,
   output logic [DW-1:0]    commit_link
);

   vs_state_e        state_q, state_d;
   logic [VEC_W-1:0] vec_q;
   logic [DW-1:0]    link_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         VS_IDLE: if (start) state_d = VS_REQ;
         VS_REQ:  state_d = VS_WAIT;
         VS_WAIT: if (mem_valid) state_d = VS_IDLE;
         default: state_d = VS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VS_IDLE;
         vec_q   <= '0;
         link_q  <= '0;
      end else begin
         state_q <= state_d;
         if (start && state_q == VS_IDLE) begin
            vec_q  <= vec;
            link_q <= link_in;
         end
      end
   end

   assign mem_req     = (state_q == VS_REQ);
   assign mem_addr    = {{(DW-VEC_W){1'b0}}, vec_q};
   assign busy        = (state_q != VS_IDLE);
   assign commit      = (state_q == VS_WAIT) && mem_valid;
   assign commit_pc   = mem_rdata;
   assign commit_link = link_q;

endmodule

// File: rtl/fcu_commit.sv
// Output register stage: program counter, link write and completion strobe.
module fcu_commit #(
   parameter int          DW       = 16,
   parameter logic [15:0] RESET_PC = 16'h3000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fast_go,
   input  logic [DW-1:0] fast_pc,
   input  logic          fast_link_en,
   input  logic [DW-1:0] fast_link,
   input  logic          slow_go,
   input  logic [DW-1:0] slow_pc,
   input  logic [DW-1:0] slow_link,
   output logic [DW-1:0] pc_out,
   output logic          link_we,
   output logic [DW-1:0] link_data,
   output logic          done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_out    <= DW'(RESET_PC);
         link_we   <= 1'b0;
         link_data <= '0;
         done      <= 1'b0;
      end else begin
         done    <= slow_go | fast_go;
         link_we <= slow_go | (fast_go & fast_link_en);
         if (slow_go) begin
            pc_out    <= slow_pc;
            link_data <= slow_link;
         end else if (fast_go) begin
            pc_out <= fast_pc;
            if (fast_link_en) link_data <= fast_link;
         end
      end
   end

endmodule

// File: rtl/flow_call_unit.sv
module flow_call_unit
   import fcu_pkg::*;
#(
   parameter int          DW       = 16,
   parameter int          NREG     = 8,
   parameter int          OFS_W    = 11,
   parameter int          VEC_W    = 8,
   parameter int          LINK_IDX = 7,
   parameter logic [15:0] RESET_PC = 16'h3000,
   localparam int         SEL_W    = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [1:0]         instr_op,
   input  logic [OFS_W-1:0]   instr_field,
   input  logic [SEL_W-1:0]   instr_rsel,
   input  logic [DW-1:0]      pc_inc,
   input  logic [NREG*DW-1:0] rf_flat,
   output logic               mem_req,
   output logic [DW-1:0]      mem_addr,
   input  logic               mem_valid,
   input  logic [DW-1:0]      mem_rdata,
   output logic [DW-1:0]      pc_out,
   output logic               link_we,
   output logic [DW-1:0]      link_data,
   output logic               done,
   output logic               busy
);

   if (VEC_W > OFS_W)        begin : g_chk_vec  $error("trap number wider than field"); end
   if (OFS_W > DW)           begin : g_chk_ofs  $error("offset wider than datapath"); end
   if ((1 << SEL_W) != NREG) begin : g_chk_nreg $error("register count not a power of two"); end
   if (LINK_IDX >= NREG)     begin : g_chk_link $error("link index out of range"); end

   logic          accept;
   logic [DW-1:0] fast_target;
   logic          fast_link_en;
   logic          is_fast;
   logic          trap_start;
   logic          slow_go;
   logic [DW-1:0] slow_pc;
   logic [DW-1:0] slow_link;

   assign accept     = instr_valid && !busy;
   assign trap_start = accept && !is_fast;

   fcu_target #(
      .DW(DW), .NREG(NREG), .OFS_W(OFS_W), .LINK_IDX(LINK_IDX)
   ) u_target (
      .op      (instr_op),
      .field   (instr_field),
      .sel     (instr_rsel),
      .pc_inc  (pc_inc),
      .rf_flat (rf_flat),
      .target  (fast_target),
      .link_en (fast_link_en),
      .is_fast (is_fast)
   );

   fcu_vec_seq #(
      .DW(DW), .VEC_W(VEC_W)
   ) u_vec (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (trap_start),
      .vec         (instr_field[VEC_W-1:0]),
      .link_in     (pc_inc),
      .mem_valid   (mem_valid),
      .mem_rdata   (mem_rdata),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .busy        (busy),
      .commit      (slow_go),
      .commit_pc   (slow_pc),
      .commit_link (slow_link)
   );

   fcu_commit #(
      .DW(DW), .RESET_PC(RESET_PC)
   ) u_commit (
      .clk          (clk),
      .rst_n        (rst_n),
      .fast_go      (accept && is_fast),
      .fast_pc      (fast_target),
      .fast_link_en (fast_link_en),
      .fast_link    (pc_inc),
      .slow_go      (slow_go),
      .slow_pc      (slow_pc),
      .slow_link    (slow_link),
      .pc_out       (pc_out),
      .link_we      (link_we),
      .link_data    (link_data),
      .done         (done)
   );

endmodule

// File: rtl/fcu_chk.sv
module fcu_chk #(
   parameter int DW    = 16,
   parameter int VEC_W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic [DW-1:0] mem_addr,
   input logic          mem_valid,
   input logic [DW-1:0] mem_rdata,
   input logic [DW-1:0] pc_out,
   input logic          link_we,
   input logic          done,
   input logic          busy
);

   // R2: the request lasts one cycle
   assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R2: request address stays inside the vector table
   assert_req_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr >> VEC_W) == '0 && busy));

   // R3: valid data while waiting commits the fetched word
   assert_trap_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req && mem_valid) |=> (done && link_we && !busy && pc_out == $past(mem_rdata)));

   // R7: link write only together with completion
   assert_link_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> done);

   // R8: nothing commits while a fetch is outstanding
   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(!mem_req && mem_valid)) |=> ($stable(pc_out) && !done));

endmodule

bind flow_call_unit fcu_chk #(.DW(DW), .VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_valid (mem_valid),
   .mem_rdata (mem_rdata),
   .pc_out    (pc_out),
   .link_we   (link_we),
   .done      (done),
   .busy      (busy)
);

// File: tb/sim_flow_call_unit.sv
`timescale 1ns/1ps
module sim_flow_call_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         instr_valid = 1'b0;
   logic [1:0]   instr_op = 2'd0;
   logic [10:0]  instr_field = '0;
   logic [2:0]   instr_rsel = '0;
   logic [15:0]  pc_inc = '0;
   logic [127:0] rf_flat;
   logic         mem_req;
   logic [15:0]  mem_addr;
   logic         mem_valid = 1'b0;
   logic [15:0]  mem_rdata = '0;
   logic [15:0]  pc_out;
   logic         link_we;
   logic [15:0]  link_data;
   logic         done;
   logic         busy;

   logic [15:0] rf [8];
   int nchk = 0;
   int nfail = 0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   always_comb for (int i = 0; i < 8; i++) rf_flat[i*16 +: 16] = rf[i];

   flow_call_unit u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_field(instr_field), .instr_rsel(instr_rsel), .pc_inc(pc_inc),
      .rf_flat(rf_flat), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata), .pc_out(pc_out),
      .link_we(link_we), .link_data(link_data), .done(done), .busy(busy)
   );

   task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] vt(logic [7:0] v);
      return 16'h0200 + 16'(v) * 16'd16;
   endfunction

   // ---------------- behavioural reference model ----------------
   int          m_st;      // 0 idle, 1 request, 2 waiting
   logic [15:0] m_pc, m_ldata, m_addr, m_held;
   logic        m_done, m_lwe, m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_pc = 16'h3000; m_done = 0; m_lwe = 0; m_req = 0;
         m_ldata = 0; m_addr = 0; m_held = 0;
      end else begin
         m_done = 0; m_lwe = 0; m_req = 0;
         if (m_st == 0) begin
            if (instr_valid) begin
               case (instr_op)
                  2'd0: begin m_st = 1; m_req = 1; m_addr = {8'h00, instr_field[7:0]}; m_held = pc_inc; end
                  2'd1: begin m_pc = pc_inc + 16'($signed(instr_field)); m_lwe = 1; m_ldata = pc_inc; m_done = 1; end
                  2'd2: begin m_pc = rf[instr_rsel]; m_lwe = 1; m_ldata = pc_inc; m_done = 1; end
                  default: begin m_pc = rf[7]; m_done = 1; end
               endcase
            end
         end else if (m_st == 1) begin
            m_st = 2;
         end else if (mem_valid) begin
            m_pc = mem_rdata; m_lwe = 1; m_ldata = m_held; m_done = 1; m_st = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cmp(cur_tag, "pc_out", pc_out, m_pc);
         cmp(cur_tag, "done", 16'(done), 16'(m_done));
         cmp(cur_tag, "link_we", 16'(link_we), 16'(m_lwe));
         if (m_lwe) cmp(cur_tag, "link_data", link_data, m_ldata);
         cmp(cur_tag, "mem_req", 16'(mem_req), 16'(m_req));
         if (m_req) cmp(cur_tag, "mem_addr", mem_addr, m_addr);
         cmp(cur_tag, "busy", 16'(busy), 16'(m_st != 0));
      end
   end

   // external register file: link writes land between edges
   always @(negedge clk) if (link_we) rf[7] <= link_data;

   // ---------------- stimulus helpers ----------------
   task automatic present(logic [1:0] op, logic [10:0] f, logic [2:0] s, logic [15:0] pci);
      instr_valid = 1'b1; instr_op = op; instr_field = f; instr_rsel = s; pc_inc = pci;
   endtask

   task automatic fast_op(string tag, logic [1:0] op, logic [10:0] f, logic [2:0] s,
                          logic [15:0] pci, logic [15:0] exp_pc, logic exp_lwe);
      cur_tag = tag;
      present(op, f, s, pci);
      @(negedge clk);
      instr_valid = 1'b0;
      cmp(tag, "pc after op", pc_out, exp_pc);
      cmp(tag, "done after op", 16'(done), 16'd1);
      cmp(tag, "link_we after op", 16'(link_we), 16'(exp_lwe));
      if (exp_lwe) cmp(tag, "link value", link_data, pci);
      @(negedge clk);
      cmp("R7", "done drops", 16'(done), 16'd0);
   endtask

   task automatic trap_op(logic [7:0] v, logic [15:0] pci, int lat, bit spur, bit poke);
      cur_tag = "R2";
      present(2'd0, {3'b101, v}, 3'd0, pci);
      @(negedge clk);
      instr_valid = 1'b0;
      cmp("R2", "request", 16'(mem_req), 16'd1);
      cmp("R2", "table address", mem_addr, {8'h00, v});
      if (spur) begin
         cur_tag = "R9";
         mem_valid = 1'b1; mem_rdata = 16'hDEAD;
      end
      @(negedge clk);
      mem_valid = 1'b0;
      cmp("R2", "request one cycle", 16'(mem_req), 16'd0);
      cmp("R9", "no early commit", 16'(done), 16'd0);
      cur_tag = "R8";
      for (int k = 0; k < lat; k++) begin
         if (poke) present(2'd1, 11'h010, 3'd0, 16'h7777);
         @(negedge clk);
         instr_valid = 1'b0;
         cmp("R8", "ignored while busy", 16'(done), 16'd0);
      end
      cur_tag = "R3";
      mem_valid = 1'b1; mem_rdata = vt(v);
      @(negedge clk);
      mem_valid = 1'b0;
      cmp("R3", "trap target", pc_out, vt(v));
      cmp("R3", "trap link", link_data, pci);
      cmp("R3", "trap link_we", 16'(link_we), 16'd1);
      cmp("R3", "busy clear", 16'(busy), 16'd0);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) rf[i] = 16'h1000 * 16'(i) + 16'h0011;
      rf[3] = 16'h4321;
      repeat (2) @(negedge clk);
      cmp("R1", "pc in reset", pc_out, 16'h3000);
      cmp("R1", "req in reset", 16'(mem_req), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1", "pc after reset", pc_out, 16'h3000);
      cmp("R1", "done after reset", 16'(done), 16'd0);
      cmp("R1", "busy after reset", 16'(busy), 16'd0);
      cmp("R1", "link_we after reset", 16'(link_we), 16'd0);

      // R9: stray valid while idle
      cur_tag = "R9";
      mem_valid = 1'b1; mem_rdata = 16'hBEEF;
      @(negedge clk);
      mem_valid = 1'b0;
      cmp("R9", "idle valid ignored pc", pc_out, 16'h3000);
      cmp("R9", "idle valid ignored done", 16'(done), 16'd0);

      // R4: offset extremes
      fast_op("R4", 2'd1, 11'h3FF, 3'd0, 16'h3001, 16'h3400, 1'b1);
      fast_op("R4", 2'd1, 11'h400, 3'd0, 16'h3400, 16'h3000, 1'b1);
      // R5: register call, then call through register 7
      fast_op("R5", 2'd2, 11'h000, 3'd3, 16'h3010, 16'h4321, 1'b1);
      begin
         logic [15:0] old7;
         old7 = rf[7];
         cmp("R5", "old link before call", old7, 16'h3011 - 16'h0001);
         fast_op("R5", 2'd2, 11'h000, 3'd7, 16'h4322, old7, 1'b1);
      end
      // R6: return to the link just written
      fast_op("R6", 2'd3, 11'h000, 3'd0, 16'h3011, 16'h4322, 1'b0);

      // R2 R3 R9: zero-latency trap with a strobe in the request cycle
      trap_op(8'h25, 16'h3020, 0, 1'b1, 1'b0);
      // R8: long wait with operations presented while busy
      trap_op(8'hFF, 16'h3030, 3, 1'b0, 1'b1);
      trap_op(8'h00, 16'h3040, 1, 1'b0, 1'b0);
      // return after a trap goes back to its link value
      fast_op("R6", 2'd3, 11'h000, 3'd0, 16'h0201, 16'h3040, 1'b0);

      // R7: back-to-back commits
      cur_tag = "R7";
      present(2'd1, 11'h002, 3'd0, 16'h3100);
      @(negedge clk);
      cmp("R7", "first done", 16'(done), 16'd1);
      present(2'd1, 11'h7FE, 3'd0, 16'h3200);
      @(negedge clk);
      instr_valid = 1'b0;
      cmp("R7", "second done", 16'(done), 16'd1);
      cmp("R7", "second target", pc_out, 16'h31FE);
      @(negedge clk);
      cmp("R7", "done ends", 16'(done), 16'd0);
      repeat (2) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule